// File: doc/BRIEF.md
# Prioritised region memory protection unit

This block decides, in the same cycle as an access is presented, which memory attributes and permissions apply to a 32-bit address. It holds a bank of programmable regions. Each region has a base, a power-of-two size, an enable, a three-bit access-permission code, an execute-never bit, a memory type, a shareability bit and a cache policy. Regions may overlap, and the region with the highest index among those that match supplies the result.

When the unit is switched off, or no enabled region covers the address, the attributes come from a fixed default map. The cache policy in the lower half of that map follows the instruction-cache and data-cache enable inputs. The top sixteenth of the map turns executable only when the high-vector input is set. A small write port programs the regions and the unit enable. It accepts writes only from privileged software. A build parameter sets the region count to 0, 8 or 12. With 0 regions the unit cannot be enabled, and every lookup uses the default map.

Top module: `prot_region_unit`

## Requirements
- R1: NUM_REGIONS is 0, 8 or 12. With 0, a write that would enable the unit or program a region has no effect: `hit` stays 0 and every lookup returns default-map attributes.
- R2: A region matches when its enable is set and address bits [31:L] equal its base bits [31:L], where L is the stored log2 size. The size write carries L in wdata[6:1] and the region enable in wdata[0]. L is clamped to 5..32, so regions run from 32 bytes to 4 GB. The base write carries base bits [31:5] in wdata[31:5].
- R3: When the unit is enabled and several regions match, the highest-indexed one wins. `hit` is 1 and `hit_idx` gives its index. When nothing hits, `hit_idx` is 0.
- R4: On a hit, the outputs come from the winning region's attribute write: wdata[2:0] is the permission code, wdata[3] is execute-never, wdata[5:4] is the type (0 normal, 1 device, 2 strongly ordered), wdata[6] is shared, and wdata[8:7] is the policy (0 non-cacheable, 1 write-through, 2 write-back write-allocate / cacheable).
- R5: `cfg_kind` selects the target: 0 control (wdata[0] is the unit enable), 1 base, 2 size/enable, 3 attributes, with `cfg_idx` naming the region. A write with `cfg_priv` low changes nothing, and `cfg_err` is 1 in the cycle after it. After any other cycle `cfg_err` is 0.
- R6: Default map, 0x80000000-0x9FFFFFFF: device, non-shared. 0xA0000000-0xBFFFFFFF: device, shared. 0xC0000000-0xEFFFFFFF: strongly ordered, shared. All three ranges are non-cacheable and execute-never.
- R7: Default map, 0xF0000000-0xFFFFFFFF: strongly ordered and shared for data, normal and non-shared for fetches, non-cacheable for both. Execute-never equals the inverse of `hivec`.
- R8: Default map, 0x00000000-0x7FFFFFFF, fetches: normal, non-shared, executable. The policy is 2 with `icache_en` high and 0 with it low.
- R9: Default map, 0x00000000-0x7FFFFFFF, data with `dcache_en` high: policy 2 and non-shared below 0x40000000, policy 1 and non-shared for 0x40000000-0x5FFFFFFF, policy 0 and shared for 0x60000000-0x7FFFFFFF. With `dcache_en` low, the whole range is policy 0 and shared. The type is always normal.
- R10: The permission code gives these rights. 0: none. 1: privileged read/write. 2: privileged read/write, user read. 3: read/write for all. 5: privileged read. 6: read for all. 4 and 7: none. A read or a fetch without read rights, or a write without write rights, sets `perm_fault` in the same cycle. Default-map accesses have full read/write rights.
- R11: A fetch (`acc_kind` 2) whose resulting execute-never is 1 sets `perm_fault`. Reads are `acc_kind` 0 and writes are `acc_kind` 1.
- R12: Out of reset the unit is disabled, all regions are off and `cfg_err` is 0. While the unit is disabled, lookups use the default map even where enabled regions match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_priv | input | 1 | Writer is privileged |
| cfg_kind | input | 2 | Write target: control, base, size, attributes |
| cfg_idx | input | 4 | Region index for region writes |
| cfg_wdata | input | 32 | Write data |
| cfg_err | output | 1 | Rejected unprivileged write in the previous cycle |
| acc_addr | input | 32 | Access address |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch |
| acc_priv | input | 1 | Access is privileged |
| icache_en | input | 1 | Instruction cache enabled |
| dcache_en | input | 1 | Data cache enabled |
| hivec | input | 1 | High vectors selected |
| hit | output | 1 | An enabled region supplied the attributes |
| hit_idx | output | 4 | Index of the winning region |
| mem_type | output | 2 | 0 normal, 1 device, 2 strongly ordered |
| shared | output | 1 | Shareable |
| cache_pol | output | 2 | 0 non-cacheable, 1 write-through, 2 write-back/cacheable |
| xn | output | 1 | Execute-never |
| perm_fault | output | 1 | Access denied |

## Verification
The lookup is combinational from the registered region bank. A corrupted base, size, enable or attribute field therefore shows at the ports on the first lookup that falls inside the affected region: as a wrong `hit_idx`, a missed hit or a wrong attribute, in the same cycle. A bad priority scan shows only where regions overlap, so lookups are placed just inside and just outside nested regions. A wrong unit-enable or write-rejection state shows one cycle after the write: `cfg_err` goes wrong, and the next lookup comes from the wrong map.

// File: rtl/prot_pkg.sv
package prot_pkg;

    typedef enum logic [1:0] {
        MT_NORMAL = 2'd0,
        MT_DEVICE = 2'd1,
        MT_STRONG = 2'd2
    } mem_type_e;

    typedef enum logic [1:0] {
        CP_NONE = 2'd0,
        CP_WT   = 2'd1,
        CP_WBWA = 2'd2
    } cache_pol_e;

    typedef enum logic [1:0] {
        AK_READ  = 2'd0,
        AK_WRITE = 2'd1,
        AK_FETCH = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        CK_CTRL = 2'd0,
        CK_BASE = 2'd1,
        CK_SIZE = 2'd2,
        CK_ATTR = 2'd3
    } cfg_kind_e;

    localparam int unsigned LG_MIN = 5;
    localparam int unsigned LG_MAX = 32;

    typedef struct packed {
        logic [26:0] base;
        logic [5:0]  lg;
        logic        en;
        logic [2:0]  ap;
        logic        xn;
        logic [1:0]  mtype;
        logic        shared;
        logic [1:0]  cpol;
    } region_t;

    typedef struct packed {
        logic [1:0] mtype;
        logic       shared;
        logic [1:0] cpol;
        logic       xn;
    } attr_t;

endpackage

// File: rtl/prot_region_match.sv
module prot_region_match
    import prot_pkg::*;
(
    input  region_t     rgn,
    input  logic [31:0] addr,
    output logic        match
);
    logic [31:0] mask;

    always_comb begin
        if (rgn.lg >= 6'(LG_MAX)) begin
            mask = '0;
        end else begin
            mask = ~((32'd1 << rgn.lg[4:0]) - 32'd1);
        end
        match = rgn.en && (((addr ^ {rgn.base, 5'b0}) & mask) == 32'd0);
    end
endmodule

// File: rtl/prot_default_map.sv
module prot_default_map
    import prot_pkg::*;
(
    input  logic [3:0] top_nib,
    input  logic       fetch,
    input  logic       icache_en,
    input  logic       dcache_en,
    input  logic       hivec,
    output attr_t      attr
);
    always_comb begin
        attr = '{mtype: MT_NORMAL, shared: 1'b0, cpol: CP_NONE, xn: 1'b0};
        unique case (top_nib)
            4'hF: begin
                attr.mtype  = fetch ? MT_NORMAL : MT_STRONG;
                attr.shared = !fetch;
                attr.xn     = !hivec;
            end
            4'hC, 4'hD, 4'hE: begin
                attr.mtype  = MT_STRONG;
                attr.shared = 1'b1;
                attr.xn     = 1'b1;
            end
            4'hA, 4'hB: begin
                attr.mtype  = MT_DEVICE;
                attr.shared = 1'b1;
                attr.xn     = 1'b1;
            end
            4'h8, 4'h9: begin
                attr.mtype  = MT_DEVICE;
                attr.xn     = 1'b1;
            end
            default: begin
                if (fetch) begin
                    attr.cpol = icache_en ? CP_WBWA : CP_NONE;
                end else if (!dcache_en || top_nib[2:1] == 2'b11) begin
                    attr.shared = 1'b1;
                end else if (top_nib[2]) begin
                    attr.cpol = CP_WT;
                end else begin
                    attr.cpol = CP_WBWA;
                end
            end
        endcase
    end
endmodule

// File: rtl/prot_perm_check.sv
module prot_perm_check
    import prot_pkg::*;
(
    input  logic [2:0] ap,
    input  logic [1:0] kind,
    input  logic       priv,
    input  logic       xn,
    output logic       fault
);
    logic rd_ok;
    logic wr_ok;

    always_comb begin
        rd_ok = 1'b0;
        wr_ok = 1'b0;
        case (ap)
            3'd1: begin rd_ok = priv; wr_ok = priv; end
            3'd2: begin rd_ok = 1'b1; wr_ok = priv; end
            3'd3: begin rd_ok = 1'b1; wr_ok = 1'b1; end
            3'd5: begin rd_ok = priv; end
            3'd6: begin rd_ok = 1'b1; end
            default: ;
        endcase
        if (kind == AK_WRITE) begin
            fault = !wr_ok;
        end else begin
            fault = !rd_ok || (kind == AK_FETCH && xn);
        end
    end
endmodule

// File: rtl/prot_region_unit.sv
module prot_region_unit
    import prot_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic        cfg_priv,
    input  logic [1:0]  cfg_kind,
    input  logic [3:0]  cfg_idx,
    input  logic [31:0] cfg_wdata,
    output logic        cfg_err,
    input  logic [31:0] acc_addr,
    input  logic [1:0]  acc_kind,
    input  logic        acc_priv,
    input  logic        icache_en,
    input  logic        dcache_en,
    input  logic        hivec,
    output logic        hit,
    output logic [3:0]  hit_idx,
    output logic [1:0]  mem_type,
    output logic        shared,
    output logic [1:0]  cache_pol,
    output logic        xn,
    output logic        perm_fault
);
    localparam int unsigned NR = (NUM_REGIONS == 0) ? 1 : NUM_REGIONS;
    localparam logic HAS_RGN = (NUM_REGIONS != 0);

    if (!(NUM_REGIONS == 0 || NUM_REGIONS == 8 || NUM_REGIONS == 12)) begin : g_bad_count
        $error("NUM_REGIONS must be 0, 8 or 12");
    end

    typedef struct packed {
        logic             unit_en;
        logic             err;
        region_t [NR-1:0] rgn;
    } state_t;

    state_t st_d, st_q;

    // next-state: configuration port
    always_comb begin
        logic [5:0] lg_in;
        st_d     = st_q;
        st_d.err = 1'b0;
        lg_in    = cfg_wdata[6:1];
        if (lg_in < 6'(LG_MIN)) lg_in = 6'(LG_MIN);
        if (lg_in > 6'(LG_MAX)) lg_in = 6'(LG_MAX);
        if (cfg_we) begin
            if (!cfg_priv) begin
                st_d.err = 1'b1;
            end else if (cfg_kind == CK_CTRL) begin
                st_d.unit_en = cfg_wdata[0] && HAS_RGN;
            end else if (HAS_RGN) begin
                for (int i = 0; i < int'(NR); i++) begin
                    if (cfg_idx == 4'(i)) begin
                        unique case (cfg_kind)
                            CK_BASE: st_d.rgn[i].base = cfg_wdata[31:5];
                            CK_SIZE: begin
                                st_d.rgn[i].en = cfg_wdata[0];
                                st_d.rgn[i].lg = lg_in;
                            end
                            CK_ATTR: begin
                                st_d.rgn[i].ap     = cfg_wdata[2:0];
                                st_d.rgn[i].xn     = cfg_wdata[3];
                                st_d.rgn[i].mtype  = cfg_wdata[5:4];
                                st_d.rgn[i].shared = cfg_wdata[6];
                                st_d.rgn[i].cpol   = cfg_wdata[8:7];
                            end
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.unit_en <= 1'b0;
            st_q.err     <= 1'b0;
            for (int i = 0; i < int'(NR); i++) begin
                st_q.rgn[i]    <= '0;
                st_q.rgn[i].lg <= 6'(LG_MIN);
            end
        end else begin
            st_q <= st_d;
        end
    end

    // lookup path
    logic [NR-1:0] match;

    for (genvar g = 0; g < int'(NR); g++) begin : g_match
        prot_region_match u_match (
            .rgn   (st_q.rgn[g]),
            .addr  (acc_addr),
            .match (match[g])
        );
    end

    logic    any_match;
    logic [3:0] win;
    region_t sel;

    always_comb begin
        any_match = 1'b0;
        win       = 4'd0;
        for (int i = 0; i < int'(NUM_REGIONS); i++) begin
            if (match[i]) begin
                any_match = 1'b1;
                win       = 4'(i);
            end
        end
        sel = st_q.rgn[0];
        for (int i = 0; i < int'(NR); i++) begin
            if (win == 4'(i)) sel = st_q.rgn[i];
        end
    end

    attr_t dflt;

    prot_default_map u_dflt (
        .top_nib   (acc_addr[31:28]),
        .fetch     (acc_kind == AK_FETCH),
        .icache_en (icache_en),
        .dcache_en (dcache_en),
        .hivec     (hivec),
        .attr      (dflt)
    );

    logic       use_rgn;
    attr_t      eff;
    logic [2:0] ap_eff;

    always_comb begin
        use_rgn = st_q.unit_en && any_match;
        if (use_rgn) begin
            eff    = '{mtype: sel.mtype, shared: sel.shared, cpol: sel.cpol, xn: sel.xn};
            ap_eff = sel.ap;
        end else begin
            eff    = dflt;
            ap_eff = 3'd3;
        end
    end

    prot_perm_check u_perm (
        .ap    (ap_eff),
        .kind  (acc_kind),
        .priv  (acc_priv),
        .xn    (eff.xn),
        .fault (perm_fault)
    );

    assign cfg_err   = st_q.err;
    assign hit       = use_rgn;
    assign hit_idx   = use_rgn ? win : 4'd0;
    assign mem_type  = eff.mtype;
    assign shared    = eff.shared;
    assign cache_pol = eff.cpol;
    assign xn        = eff.xn;
endmodule

// File: rtl/prot_region_unit_chk.sv
module prot_region_unit_chk #(
    parameter int unsigned NUM_REGIONS = 12
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic        cfg_priv,
    input logic        cfg_err,
    input logic [31:0] acc_addr,
    input logic [1:0]  acc_kind,
    input logic        hit,
    input logic [3:0]  hit_idx,
    input logic [1:0]  mem_type,
    input logic        shared,
    input logic        xn,
    input logic        perm_fault
);
    // R5
    unpriv_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_priv) |=> cfg_err);

    // R5
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && !cfg_priv) |=> !cfg_err);

    // R3
    idx_zero_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_idx == 4'd0));

    // R3
    idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (32'(hit_idx) < NUM_REGIONS));

    // R1
    empty_never_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (NUM_REGIONS == 0) |-> !hit);

    // R11
    fetch_xn_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == 2'd2 && xn) |-> perm_fault);

    // R6
    device_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && acc_addr[31:29] == 3'b100) |-> (mem_type == 2'd1 && !shared && xn));
endmodule

bind prot_region_unit prot_region_unit_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_priv   (cfg_priv),
    .cfg_err    (cfg_err),
    .acc_addr   (acc_addr),
    .acc_kind   (acc_kind),
    .hit        (hit),
    .hit_idx    (hit_idx),
    .mem_type   (mem_type),
    .shared     (shared),
    .xn         (xn),
    .perm_fault (perm_fault)
);

// File: tb/prot_region_unit_tb.sv
module prot_region_unit_tb;
    localparam int NREG = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_priv = 1'b0;
    logic [1:0]  cfg_kind = '0;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic        acc_priv = 1'b0, icache_en = 1'b0, dcache_en = 1'b0, hivec = 1'b0;

    logic        cfg_err, hit, shared, xn, perm_fault;
    logic [3:0]  hit_idx;
    logic [1:0]  mem_type, cache_pol;
    logic        e_cfg_err, e_hit, e_shared, e_xn, e_fault;
    logic [3:0]  e_idx;
    logic [1:0]  e_mt, e_cp;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    prot_region_unit #(.NUM_REGIONS(NREG)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
        .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_err(cfg_err),
        .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_priv(acc_priv),
        .icache_en(icache_en), .dcache_en(dcache_en), .hivec(hivec),
        .hit(hit), .hit_idx(hit_idx), .mem_type(mem_type), .shared(shared),
        .cache_pol(cache_pol), .xn(xn), .perm_fault(perm_fault));

    prot_region_unit #(.NUM_REGIONS(0)) u_dut_empty (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
        .cfg_kind(cfg_kind), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_err(e_cfg_err),
        .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_priv(acc_priv),
        .icache_en(icache_en), .dcache_en(dcache_en), .hivec(hivec),
        .hit(e_hit), .hit_idx(e_idx), .mem_type(e_mt), .shared(e_shared),
        .cache_pol(e_cp), .xn(e_xn), .perm_fault(e_fault));

    // bench model of programmed state
    logic [31:0] m_base [NREG];
    int          m_lg   [NREG];
    logic        m_en   [NREG];
    logic [8:0]  m_attr [NREG];
    logic        m_unit = 1'b0;

    // {mt, sh, cp, xn}
    function automatic logic [5:0] dflt_attr(logic [31:0] a, logic [1:0] k,
                                             logic ic, logic dc, logic hv);
        logic [3:0] n = a[31:28];
        if (n == 4'hF) return (k == 2'd2) ? {2'd0, 1'b0, 2'd0, !hv} : {2'd2, 1'b1, 2'd0, !hv};
        if (n >= 4'hC) return {2'd2, 1'b1, 2'd0, 1'b1};
        if (n >= 4'hA) return {2'd1, 1'b1, 2'd0, 1'b1};
        if (n >= 4'h8) return {2'd1, 1'b0, 2'd0, 1'b1};
        if (k == 2'd2) return {2'd0, 1'b0, ic ? 2'd2 : 2'd0, 1'b0};
        if (!dc || n >= 4'h6) return {2'd0, 1'b1, 2'd0, 1'b0};
        if (n >= 4'h4) return {2'd0, 1'b0, 2'd1, 1'b0};
        return {2'd0, 1'b0, 2'd2, 1'b0};
    endfunction

    function automatic logic ap_fault(logic [2:0] ap, logic [1:0] k, logic p, logic x);
        logic r, w;
        case (ap)
            3'd1: begin r = p;    w = p;    end
            3'd2: begin r = 1'b1; w = p;    end
            3'd3: begin r = 1'b1; w = 1'b1; end
            3'd5: begin r = p;    w = 1'b0; end
            3'd6: begin r = 1'b1; w = 1'b0; end
            default: begin r = 1'b0; w = 1'b0; end
        endcase
        if (k == 2'd1) return !w;
        return !r || (k == 2'd2 && x);
    endfunction

    // {hit, idx, mt, sh, cp, xn, fault}
    function automatic logic [12:0] expect_of(logic [31:0] a, logic [1:0] k, logic p,
                                              logic ic, logic dc, logic hv, logic full);
        logic       h = 1'b0;
        logic [3:0] w = 4'd0;
        logic [5:0] at;
        logic [2:0] ap = 3'd3;
        if (full && m_unit) begin
            for (int i = 0; i < NREG; i++) begin
                if (m_en[i] && (m_lg[i] >= 32 || (a >> m_lg[i]) == (m_base[i] >> m_lg[i]))) begin
                    h = 1'b1;
                    w = 4'(i);
                end
            end
        end
        if (h) begin
            at = {m_attr[w][5:4], m_attr[w][6], m_attr[w][8:7], m_attr[w][3]};
            ap = m_attr[w][2:0];
        end else begin
            at = dflt_attr(a, k, ic, dc, hv);
        end
        return {h, w, at, ap_fault(ap, k, p, at[0])};
    endfunction

    typedef struct {
        logic [12:0] exp_full;
        logic [12:0] exp_empty;
        logic [31:0] addr;
        string       tag;
    } item_t;

    item_t sb_q[$];
    event  look_ev;

    task automatic note(logic ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // monitor: pops expectations and compares with the ports
    initial begin
        forever begin
            item_t it;
            @(look_ev);
            #1;
            it = sb_q.pop_front();
            note({hit, hit_idx, mem_type, shared, cache_pol, xn, perm_fault} == it.exp_full,
                 it.tag, $sformatf("lookup %h", it.addr),
                 32'({hit, hit_idx, mem_type, shared, cache_pol, xn, perm_fault}), 32'(it.exp_full));
            // R1: region-less build always answers from the default map
            note({e_hit, e_idx, e_mt, e_shared, e_cp, e_xn, e_fault} == it.exp_empty,
                 "R1", $sformatf("empty lookup %h", it.addr),
                 32'({e_hit, e_idx, e_mt, e_shared, e_cp, e_xn, e_fault}), 32'(it.exp_empty));
        end
    end

    task automatic look(logic [31:0] a, logic [1:0] k, logic p,
                        logic ic, logic dc, logic hv, string tag);
        item_t it;
        @(negedge clk);
        acc_addr = a; acc_kind = k; acc_priv = p;
        icache_en = ic; dcache_en = dc; hivec = hv;
        it.exp_full  = expect_of(a, k, p, ic, dc, hv, 1'b1);
        it.exp_empty = expect_of(a, k, p, ic, dc, hv, 1'b0);
        it.addr = a;
        it.tag  = tag;
        sb_q.push_back(it);
        -> look_ev;
        @(posedge clk);
    endtask

    task automatic cfg(logic [1:0] kd, int idx, logic [31:0] d, logic p);
        int lg;
        @(negedge clk);
        cfg_we = 1'b1; cfg_priv = p; cfg_kind = kd; cfg_idx = 4'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        // R5: error flag in the cycle after the write, on both builds
        note(cfg_err == !p, "R5", "cfg_err after write", 32'(cfg_err), 32'(!p));
        note(e_cfg_err == !p, "R5", "empty cfg_err after write", 32'(e_cfg_err), 32'(!p));
        if (p) begin
            case (kd)
                2'd0: m_unit = d[0];
                2'd1: m_base[idx] = {d[31:5], 5'b0};
                2'd2: begin
                    lg = int'(d[6:1]);
                    if (lg < 5) lg = 5;
                    if (lg > 32) lg = 32;
                    m_lg[idx] = lg;
                    m_en[idx] = d[0];
                end
                default: m_attr[idx] = d[8:0];
            endcase
        end
        @(negedge clk);
        note(cfg_err == 1'b0, "R5", "cfg_err clears", 32'(cfg_err), 32'd0);
    endtask

    function automatic logic [31:0] attr_w(logic [2:0] ap, logic x, logic [1:0] mt,
                                           logic sh, logic [1:0] cp);
        return 32'({cp, sh, mt, x, ap});
    endfunction

    task automatic region(int idx, logic [31:0] base, int lg, logic [31:0] at);
        cfg(2'd1, idx, base, 1'b1);
        cfg(2'd3, idx, at, 1'b1);
        cfg(2'd2, idx, 32'((lg << 1) | 1), 1'b1);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) begin
            m_base[i] = '0; m_lg[i] = 5; m_en[i] = 1'b0; m_attr[i] = '0;
        end
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        note(cfg_err == 1'b0, "R12", "cfg_err out of reset", 32'(cfg_err), 32'd0);
        note(hit == 1'b0, "R12", "hit out of reset", 32'(hit), 32'd0);

        // default map, data side (R9)
        look(32'h0000_1000, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R9");
        look(32'h3FFF_FFFC, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, "R9");
        look(32'h4800_0000, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, "R9");
        look(32'h6000_0000, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, "R9");
        look(32'h1000_0000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R9");
        look(32'h5000_0000, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R9");
        // fetch side (R8)
        look(32'h1000_0000, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
        look(32'h7FFF_FFFC, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
        // device and strongly ordered ranges (R6, R11)
        look(32'h8000_0000, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R6");
        look(32'h9FFF_FFFC, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, "R6");
        look(32'hA000_0000, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R6");
        look(32'hBFFF_FFFC, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R6");
        look(32'hC000_0000, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, "R6");
        look(32'hEFFF_FFFC, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R6");
        look(32'hC000_0000, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, "R11");
        // top range and high vectors (R7)
        look(32'hF000_0000, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, "R7");
        look(32'hFFFF_0000, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, "R7");
        look(32'hFFFF_0000, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, "R7");

        // program overlapping regions; unit still off (R12)
        region(0,  32'h0000_0000, 32, attr_w(3'd3, 1'b0, 2'd0, 1'b1, 2'd0));
        region(3,  32'h2000_0000, 28, attr_w(3'd6, 1'b1, 2'd1, 1'b0, 2'd0));
        region(11, 32'h2000_1000, 12, attr_w(3'd1, 1'b0, 2'd0, 1'b0, 2'd1));
        look(32'h2000_1004, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R12");
        cfg(2'd0, 0, 32'd1, 1'b1);

        // priority and attributes (R2, R3, R4)
        look(32'h2000_1004, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, "R3");
        look(32'h2000_1FFC, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R2");
        look(32'h2000_0FFC, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, "R2");
        look(32'h2000_2000, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, "R4");
        look(32'h3000_0000, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, "R3");
        look(32'h9000_0000, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, "R4");
        // permissions (R10, R11)
        look(32'h2000_1004, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, "R10");
        look(32'h2000_2000, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, "R10");
        look(32'h2000_2000, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, "R11");
        cfg(2'd3, 11, attr_w(3'd2, 1'b0, 2'd0, 1'b0, 2'd1), 1'b1);
        look(32'h2000_1004, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, "R10");
        look(32'h2000_1004, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, "R10");
        cfg(2'd3, 11, attr_w(3'd5, 1'b0, 2'd0, 1'b0, 2'd1), 1'b1);
        look(32'h2000_1004, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, "R10");
        look(32'h2000_1004, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, "R10");
        cfg(2'd3, 11, attr_w(3'd0, 1'b0, 2'd0, 1'b0, 2'd1), 1'b1);
        look(32'h2000_1004, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R10");
        cfg(2'd3, 11, attr_w(3'd7, 1'b0, 2'd0, 1'b0, 2'd1), 1'b1);
        look(32'h2000_1004, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R10");

        // unprivileged writes change nothing (R5)
        cfg(2'd2, 11, 32'h0, 1'b0);
        cfg(2'd0, 0, 32'h0, 1'b0);
        look(32'h2000_1004, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R5");

        // size clamp to 32 bytes (R2)
        region(5, 32'h5000_0040, 2, attr_w(3'd3, 1'b0, 2'd2, 1'b1, 2'd0));
        look(32'h5000_0040, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R2");
        look(32'h5000_005C, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R2");
        look(32'h5000_0060, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, "R2");

        // disabling a region and the unit (R3, R12)
        cfg(2'd2, 3, 32'(28 << 1), 1'b1);
        look(32'h2000_2000, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, "R3");
        cfg(2'd0, 0, 32'd0, 1'b1);
        look(32'h2000_1004, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, "R12");

        repeat (2) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule